// File: doc/BRIEF.md
# Serial Line-Address Pointer Controller

This block keeps the access position for one port of a frame buffer that is organised in lines. The position has two parts: a line number and a word number within that line. A new start line is shifted in one bit per clock. The word number then advances on every clock while the port is enabled. The memory array and the data path sit outside the block and use `line_addr` and `word_addr` to select the storage location.

Besides the serial load, the port can send a one-cycle command on the reset strobe, which is qualified by two control inputs. The command can return to the start of the current line, clear the position to line 0, step to the next line, or jump back to the line that was last loaded. The last loaded line is held in a preset register. A clear does not touch this register, so a later jump still returns to that line. One parameter selects the read-side or write-side variant. The two variants differ only in how they treat the command that has both control inputs low.

Top module: `line_ptr_ctrl`

## Requirements
- R1: After a synchronous reset, `line_addr` and `word_addr` are 0, and `busy` and `eol` are 0.
- R2: While `cyc_reset` is low and `addr_en` is high, one `addr_bit` is taken per rising edge, 10 bits in all, most significant first. The first bit is discarded. On the edge of the 10th bit, the remaining 9 bits become both the line and the preset, and the word goes to 0. A value of 290 or more is clamped to 289.
- R3: `busy` is 1 from the edge that takes the first serial bit until the edge that loads the 10th bit. If `addr_en` falls or `cyc_reset` rises part way through, the partial address is dropped: `busy` returns to 0 and the line and preset stay unchanged.
- R4: With `cyc_reset`=1, `line_inc`=0 and `addr_en`=1, the position goes to (0,0) and the preset is kept.
- R5: With `cyc_reset`=1, `line_inc`=1 and `addr_en`=0, the line advances by one and the word goes to 0. Line 289 wraps to line 0.
- R6: With all three of `cyc_reset`, `line_inc` and `addr_en` high, the line is loaded from the preset and the word goes to 0.
- R7: With `cyc_reset`=1, `line_inc`=0 and `addr_en`=0, the read variant (READ_SIDE=1) keeps the line and sets the word to 0. The write variant (READ_SIDE=0) leaves both line and word unchanged, because this code is the write-transfer command.
- R8: The word advances by one per rising edge only when `port_en_n` is 0, `cyc_reset` is 0 and `addr_en` is 0. Otherwise it holds, unless a command or a load moves it.
- R9: An advance while the word is at 767 leaves it at 767 and sets `eol`. `eol` stays set until a reset-strobe command or a completed serial load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| port_en_n | input | 1 | Port enable, active low, gates word advance |
| cyc_reset | input | 1 | Reset-cycle strobe that qualifies the command code |
| line_inc | input | 1 | Line-increment control |
| addr_en | input | 1 | Serial address enable, also the clear control in a reset cycle |
| addr_bit | input | 1 | Serial address bit, most significant bit first |
| line_addr | output | 9 | Current line number |
| word_addr | output | 10 | Current word number in the line |
| busy | output | 1 | Serial address load in progress |
| eol | output | 1 | Word counter has run past the last word |

## Verification
The hardest case to reach is the jump after a clear, because it depends on a preset register that is not visible at the ports. The stimulus loads line 100 through the serial input and advances the word counter. It then issues a clear and checks for (0,0), and then issues a jump. The line returning to 100 shows that the preset survived the clear. The end-of-line case is reached by running the word counter through all 768 words with the enable held low. The write-side variant runs beside the read-side one on the same inputs, so the differing hold command is checked on both instances in the same cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [2:0] {
        CMD_RUN,
        CMD_SHIFT,
        CMD_HOLD,
        CMD_CLEAR,
        CMD_NEXT,
        CMD_JUMP
    } lpc_cmd_e;

    function automatic lpc_cmd_e lpc_decode(input logic strobe,
                                            input logic inc,
                                            input logic ade);
        lpc_cmd_e c;
        if (strobe) begin
            case ({inc, ade})
                2'b00:   c = CMD_HOLD;
                2'b01:   c = CMD_CLEAR;
                2'b10:   c = CMD_NEXT;
                default: c = CMD_JUMP;
            endcase
        end else if (ade) begin
            c = CMD_SHIFT;
        end else begin
            c = CMD_RUN;
        end
        return c;
    endfunction

endpackage

// File: rtl/ptr_serial_loader.sv
module ptr_serial_loader
    import lpc_pkg::*;
#(
    parameter int ADDR_BITS = 10,
    parameter int LINES     = 290
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lpc_cmd_e             cmd,
    input  logic                 bit_in,
    output logic                 load_valid,
    output logic [ADDR_BITS-2:0] load_value,
    output logic                 busy
);
    localparam int LINE_W = ADDR_BITS - 1;
    localparam int CNT_W  = $clog2(ADDR_BITS);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(ADDR_BITS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    logic [LINE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic [LINE_W-1:0] raw;

    assign raw        = {shreg[LINE_W-2:0], bit_in};
    assign load_valid = (cmd == CMD_SHIFT) && (cnt == LAST_BIT);
    assign load_value = (raw > LAST_LINE) ? LAST_LINE : raw;
    assign busy       = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (cmd == CMD_SHIFT) begin
            shreg <= raw;
            cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
        end else begin
            cnt   <= '0;
        end
    end
endmodule

// File: rtl/ptr_line_ctr.sv
module ptr_line_ctr
    import lpc_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int LINES  = 290
) (
    input  logic              clk,
    input  logic              rst,
    input  lpc_cmd_e          cmd,
    input  logic              load_valid,
    input  logic [LINE_W-1:0] load_value,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    logic [LINE_W-1:0] preset;

    always_ff @(posedge clk) begin
        if (rst) begin
            line   <= '0;
            preset <= '0;
        end else begin
            case (cmd)
                CMD_SHIFT: if (load_valid) begin
                    line   <= load_value;
                    preset <= load_value;
                end
                CMD_CLEAR: line <= '0;
                CMD_NEXT:  line <= (line == LAST_LINE) ? '0 : line + 1'b1;
                CMD_JUMP:  line <= preset;
                default:   line <= line;
            endcase
        end
    end
endmodule

// File: rtl/ptr_word_ctr.sv
module ptr_word_ctr
    import lpc_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int WORDS     = 768,
    parameter bit READ_SIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  lpc_cmd_e          cmd,
    input  logic              en_n,
    input  logic              load_valid,
    output logic [WORD_W-1:0] word,
    output logic              eol
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    logic restart;

    generate
        if (READ_SIDE) begin : g_rd
            assign restart = (cmd == CMD_HOLD) || (cmd == CMD_CLEAR) ||
                             (cmd == CMD_NEXT) || (cmd == CMD_JUMP) ||
                             load_valid;
        end else begin : g_wr
            assign restart = (cmd == CMD_CLEAR) || (cmd == CMD_NEXT) ||
                             (cmd == CMD_JUMP) || load_valid;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            eol  <= 1'b0;
        end else if (restart) begin
            word <= '0;
            eol  <= 1'b0;
        end else if (cmd == CMD_RUN && !en_n) begin
            if (word == LAST_WORD) eol <= 1'b1;
            else                   word <= word + 1'b1;
        end
    end
endmodule

// File: rtl/line_ptr_ctrl.sv
module line_ptr_ctrl
    import lpc_pkg::*;
#(
    parameter int ADDR_BITS = 10,
    parameter int LINES     = 290,
    parameter int WORDS     = 768,
    parameter bit READ_SIDE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       port_en_n,
    input  logic                       cyc_reset,
    input  logic                       line_inc,
    input  logic                       addr_en,
    input  logic                       addr_bit,
    output logic [ADDR_BITS-2:0]       line_addr,
    output logic [$clog2(WORDS)-1:0]   word_addr,
    output logic                       busy,
    output logic                       eol
);
    localparam int LINE_W = ADDR_BITS - 1;
    localparam int WORD_W = $clog2(WORDS);

    lpc_cmd_e          cmd;
    logic              load_valid;
    logic [LINE_W-1:0] load_value;

    assign cmd = lpc_decode(cyc_reset, line_inc, addr_en);

    ptr_serial_loader #(.ADDR_BITS(ADDR_BITS), .LINES(LINES)) u_load (
        .clk(clk), .rst(rst), .cmd(cmd), .bit_in(addr_bit),
        .load_valid(load_valid), .load_value(load_value), .busy(busy)
    );

    ptr_line_ctr #(.LINE_W(LINE_W), .LINES(LINES)) u_line (
        .clk(clk), .rst(rst), .cmd(cmd), .load_valid(load_valid),
        .load_value(load_value), .line(line_addr)
    );

    ptr_word_ctr #(.WORD_W(WORD_W), .WORDS(WORDS), .READ_SIDE(READ_SIDE)) u_word (
        .clk(clk), .rst(rst), .cmd(cmd), .en_n(port_en_n),
        .load_valid(load_valid), .word(word_addr), .eol(eol)
    );
endmodule

// File: rtl/line_ptr_ctrl_chk.sv
module line_ptr_ctrl_chk #(
    parameter int ADDR_BITS = 10,
    parameter int LINES     = 290,
    parameter int WORDS     = 768
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     port_en_n,
    input logic                     cyc_reset,
    input logic                     line_inc,
    input logic                     addr_en,
    input logic                     addr_bit,
    input logic [ADDR_BITS-2:0]     line_addr,
    input logic [$clog2(WORDS)-1:0] word_addr,
    input logic                     busy,
    input logic                     eol
);
    localparam int WORD_W = $clog2(WORDS);

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(line_addr) < LINES); // R2
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!addr_en || cyc_reset) |=> !busy); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cyc_reset && !line_inc && addr_en) |=> (line_addr == '0 && word_addr == '0)); // R4
    AST_NEXT_WORD0: assert property (@(posedge clk) disable iff (rst)
        (cyc_reset && line_inc && !addr_en) |=> word_addr == '0); // R5
    AST_JUMP_WORD0: assert property (@(posedge clk) disable iff (rst)
        (cyc_reset && line_inc && addr_en) |=> word_addr == '0); // R6
    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (rst)
        (cyc_reset && !line_inc && !addr_en) |=> $stable(line_addr)); // R7
    AST_FREEZE_WORD: assert property (@(posedge clk) disable iff (rst)
        (port_en_n && !cyc_reset && !addr_en) |=> $stable(word_addr)); // R8
    AST_EOL_AT_END: assert property (@(posedge clk) disable iff (rst)
        eol |-> word_addr == WORD_W'(WORDS - 1)); // R9
endmodule

bind line_ptr_ctrl line_ptr_ctrl_chk #(
    .ADDR_BITS(ADDR_BITS), .LINES(LINES), .WORDS(WORDS)
) u_chk (.*);

// File: tb/line_ptr_ctrl_tb.sv
module line_ptr_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en_n = 1'b1, cyc_reset = 1'b0, line_inc = 1'b0;
    logic addr_en = 1'b0, addr_bit = 1'b0;
    logic [8:0] line_addr, line_w;
    logic [9:0] word_addr, word_w;
    logic busy, eol, busy_w, eol_w;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_ptr_ctrl #(.READ_SIDE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .port_en_n(port_en_n), .cyc_reset(cyc_reset),
        .line_inc(line_inc), .addr_en(addr_en), .addr_bit(addr_bit),
        .line_addr(line_addr), .word_addr(word_addr), .busy(busy), .eol(eol));

    line_ptr_ctrl #(.READ_SIDE(1'b0)) u_dut_wr (
        .clk(clk), .rst(rst), .port_en_n(port_en_n), .cyc_reset(cyc_reset),
        .line_inc(line_inc), .addr_en(addr_en), .addr_bit(addr_bit),
        .line_addr(line_w), .word_addr(word_w), .busy(busy_w), .eol(eol_w));

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(logic rs, logic inc, logic ade, logic b, logic en_n);
        @(negedge clk);
        cyc_reset = rs; line_inc = inc; addr_en = ade; addr_bit = b; port_en_n = en_n;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n, logic en_n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, en_n);
    endtask

    task automatic load(logic [9:0] a, int exp_line);
        for (int i = 9; i >= 0; i--) begin
            step(1'b0, 1'b0, 1'b1, a[i], 1'b1);
            if (i == 9) chk("R3 busy after first bit", int'(busy), 1);
        end
        chk("R3 busy cleared on load", int'(busy), 0);
        chk("R2 line after load", int'(line_addr), exp_line);
        chk("R2 word after load", int'(word_addr), 0);
        idle(1, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 line", int'(line_addr), 0);
        chk("R1 word", int'(word_addr), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 eol", int'(eol), 0);
    endtask

    task automatic t_count_and_abort();
        idle(5, 1'b0);
        chk("R8 word advanced", int'(word_addr), 5);
        idle(3, 1'b1);
        chk("R8 word frozen when disabled", int'(word_addr), 5);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 word frozen during address set", int'(word_addr), 5);
        chk("R3 busy mid load", int'(busy), 1);
        idle(1, 1'b1);
        chk("R3 busy after abort", int'(busy), 0);
        chk("R3 line kept after abort", int'(line_addr), 100);
    endtask

    task automatic t_hold();
        chk("R7 write side word before hold", int'(word_w), 5);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 read line kept", int'(line_addr), 100);
        chk("R7 read word to 0", int'(word_addr), 0);
        chk("R7 write line kept", int'(line_w), 100);
        chk("R7 write word kept", int'(word_w), 5);
    endtask

    task automatic t_clear_jump();
        idle(3, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R4 line cleared", int'(line_addr), 0);
        chk("R4 word cleared", int'(word_addr), 0);
        idle(2, 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R6 jump to preset", int'(line_addr), 100);
        chk("R6 word after jump", int'(word_addr), 0);
    endtask

    task automatic t_next();
        idle(2, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 line incremented", int'(line_addr), 101);
        chk("R5 word after increment", int'(word_addr), 0);
        load(10'h121, 289);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 line wraps", int'(line_addr), 0);
        load(10'h1FF, 289);
    endtask

    task automatic t_eol();
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        idle(767, 1'b0);
        chk("R9 word at last", int'(word_addr), 767);
        chk("R9 eol not yet", int'(eol), 0);
        idle(1, 1'b0);
        chk("R9 eol set", int'(eol), 1);
        chk("R9 word saturates", int'(word_addr), 767);
        idle(2, 1'b0);
        chk("R9 eol sticky", int'(eol), 1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 eol cleared by command", int'(eol), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        t_reset();
        load(10'h205, 5);
        load(10'h064, 100);
        t_count_and_abort();
        t_hold();
        t_clear_jump();
        t_next();
        t_eol();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule